// File: doc/BRIEF.md
# Configurable Registered/Combinatorial Output Cell

This block is one output cell of a sum-of-products logic fabric. It takes the OR sum built by the product-term array and an output-enable term. It then presents the result at a pin, either straight through or through a D flip-flop clocked by the shared clock. Two configuration bits choose the source of the output and its polarity. The same choice decides whether the feedback line into the array carries the flip-flop state or the pin value.

The flip-flop has four ways to change state:
- A global asynchronous reset clears it at once.
- A power-up reset clears it in the same way.
- A global synchronous preset sets it on the next rising edge.
- A test preload port writes a chosen value into it on a rising edge.

The tristate driver is not modelled electrically. It appears as a separate enable output, and the value seen on the pin while the driver is off comes in on its own input.

Top module: `oc_cell`

## Requirements
- R1: While `areset` is 1 the stored state is 0 at once, without waiting for a clock edge. Rising clock edges that arrive during reset leave it at 0, whatever `preset`, `sum_in` or `pl_en` hold.
- R2: With no reset, preset or preload active, a rising edge of `clk` loads `sum_in` into the stored state. Between edges the state holds.
- R3: With `preset` at 1, no reset and `pl_en` at 0, the stored state is 1 after the next rising edge.
- R4: When `areset` and `preset` are both 1 at an edge, reset wins and the state stays 0.
- R5: With `pl_en` at 1 and no reset, the next rising edge loads `pl_val` into the state. This takes priority over both `sum_in` and `preset`.
- R6: While `por_n` is 0 the state is cleared, exactly as with `areset`.
- R7: In registered mode (`cfg_comb`=0), `pin_out` is the stored state when `cfg_high`=1 and its inverse when `cfg_high`=0. A cleared state therefore gives 1 at an active-low output.
- R8: In combinatorial mode (`cfg_comb`=1), `pin_out` follows `sum_in` with no clock delay. It is inverted when `cfg_high`=0.
- R9: In registered mode, `fb_out` equals the true stored state, whatever `oe_term` and `pin_in` are.
- R10: In combinatorial mode, `fb_out` equals `pin_out` when `oe_term`=1 and equals `pin_in` when `oe_term`=0.
- R11: `pin_oe` equals `oe_term` in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge active |
| por_n | input | 1 | Power-up reset, active low, asynchronous clear |
| areset | input | 1 | Global asynchronous reset term, active high |
| preset | input | 1 | Global synchronous preset term, active high |
| cfg_comb | input | 1 | 1 = combinatorial path, 0 = registered path |
| cfg_high | input | 1 | 1 = active-high output, 0 = active-low |
| sum_in | input | 1 | OR sum from the product-term array |
| oe_term | input | 1 | Output-enable product term |
| pin_in | input | 1 | Value on the pin when the driver is off |
| pl_en | input | 1 | Test preload strobe |
| pl_val | input | 1 | Value written by preload |
| pin_out | output | 1 | Value driven toward the pin |
| pin_oe | output | 1 | Tristate driver enable |
| fb_out | output | 1 | Feedback into the product-term array |

## Verification
The bench holds reset and preset together across an edge. A design that ranks the preset first would show a 1 there. It also holds reset and preload together, which would expose preload overriding the clear. Preload is then set against an active preset and an opposite sum, which catches a wrong priority order.

In registered active-low mode, the bench checks that a cleared cell drives 1 at the pin while feedback stays 0. Swapping the two polarity points would invert one of these. In registered mode, the bench turns the driver off and moves `pin_in`. A design that takes feedback from the pin there would follow it.

// File: rtl/oc_pkg.sv
package oc_pkg;
    // Mode encoding: {cfg_comb, cfg_high}
    typedef enum logic [1:0] {
        MODE_REG_LO = 2'b00,
        MODE_REG_HI = 2'b01,
        MODE_CMB_LO = 2'b10,
        MODE_CMB_HI = 2'b11
    } oc_mode_e;

    typedef struct packed {
        logic state;
    } oc_store_t;

    typedef struct packed {
        logic val;
        logic oe;
        logic fb;
    } oc_out_t;

    localparam logic STATE_CLEAR = 1'b0;
    localparam logic STATE_SET   = 1'b1;
endpackage

// File: rtl/oc_store.sv
module oc_store
    import oc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic preset,
    input  logic pl_en,
    input  logic pl_val,
    input  logic sum,
    output logic state
);
    oc_store_t st_d, st_q;

    // Priority below the asynchronous clear: preload, preset, sum.
    always_comb begin
        st_d = st_q;
        if (pl_en)       st_d.state = pl_val;
        else if (preset) st_d.state = STATE_SET;
        else             st_d.state = sum;
    end

    always_ff @(posedge clk or posedge clr) begin
        if (clr) st_q <= '{state: STATE_CLEAR};
        else     st_q <= st_d;
    end

    assign state = st_q.state;

    assert_clear_holds_R1: assert property (@(negedge clk)
        clr |-> (state == STATE_CLEAR));

    assert_capture_sum_R2: assert property (@(posedge clk) disable iff (clr)
        (!pl_en && !preset) |=> (state == $past(sum)));

    assert_preset_sets_R3: assert property (@(posedge clk) disable iff (clr)
        (preset && !pl_en) |=> (state == STATE_SET));

    assert_preload_wins_R5: assert property (@(posedge clk) disable iff (clr)
        pl_en |=> (state == $past(pl_val)));
endmodule

// File: rtl/oc_outmux.sv
module oc_outmux
    import oc_pkg::*;
(
    input  oc_mode_e mode,
    input  logic     state,
    input  logic     sum,
    input  logic     oe,
    input  logic     pin_in,
    output logic     pin_val,
    output logic     pin_oe,
    output logic     fb
);
    oc_out_t o_d;
    logic    src;

    always_comb begin
        // Output source mux: stored state or direct sum
        src = (mode == MODE_CMB_LO || mode == MODE_CMB_HI) ? sum : state;
        o_d.oe = oe;
        // Polarity mux
        o_d.val = (mode == MODE_REG_HI || mode == MODE_CMB_HI) ? src : ~src;
        // Feedback: true state in registered modes, pin value otherwise
        if (mode == MODE_REG_LO || mode == MODE_REG_HI) o_d.fb = state;
        else                                            o_d.fb = oe ? o_d.val : pin_in;
    end

    assign pin_val = o_d.val;
    assign pin_oe  = o_d.oe;
    assign fb      = o_d.fb;
endmodule

// File: rtl/oc_cell.sv
module oc_cell
    import oc_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic areset,
    input  logic preset,
    input  logic cfg_comb,
    input  logic cfg_high,
    input  logic sum_in,
    input  logic oe_term,
    input  logic pin_in,
    input  logic pl_en,
    input  logic pl_val,
    output logic pin_out,
    output logic pin_oe,
    output logic fb_out
);
    logic     clr;
    logic     state;
    oc_mode_e mode;

    assign clr  = areset | ~por_n;
    assign mode = oc_mode_e'({cfg_comb, cfg_high});

    oc_store u_store (
        .clk    (clk),
        .clr    (clr),
        .preset (preset),
        .pl_en  (pl_en),
        .pl_val (pl_val),
        .sum    (sum_in),
        .state  (state)
    );

    oc_outmux u_mux (
        .mode    (mode),
        .state   (state),
        .sum     (sum_in),
        .oe      (oe_term),
        .pin_in  (pin_in),
        .pin_val (pin_out),
        .pin_oe  (pin_oe),
        .fb      (fb_out)
    );

    assert_reg_hi_fb_R9: assert property (@(negedge clk) disable iff (clr)
        (!cfg_comb && cfg_high) |-> (fb_out == pin_out));

    assert_reg_lo_fb_R7: assert property (@(negedge clk) disable iff (clr)
        (!cfg_comb && !cfg_high) |-> (fb_out != pin_out));

    assert_cmb_fb_R10: assert property (@(negedge clk) disable iff (clr)
        cfg_comb |-> (fb_out == (oe_term ? pin_out : pin_in)));

    assert_oe_pass_R11: assert property (@(negedge clk) disable iff (clr)
        pin_oe == oe_term);
endmodule

// File: tb/oc_cell_tb.sv
module oc_cell_tb;
    logic clk = 1'b0;
    logic por_n, areset, preset, cfg_comb, cfg_high;
    logic sum_in, oe_term, pin_in, pl_en, pl_val;
    logic pin_out, pin_oe, fb_out;
    int   n_chk = 0;
    int   n_bad = 0;

    always #4 clk = ~clk;

    oc_cell u_dut (
        .clk(clk), .por_n(por_n), .areset(areset), .preset(preset),
        .cfg_comb(cfg_comb), .cfg_high(cfg_high), .sum_in(sum_in),
        .oe_term(oe_term), .pin_in(pin_in), .pl_en(pl_en), .pl_val(pl_val),
        .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    // Advance one rising edge; return 2 ns after it
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic t_powerup();
        por_n = 0; areset = 0; preset = 0; cfg_comb = 0; cfg_high = 1;
        sum_in = 1; oe_term = 1; pin_in = 0; pl_en = 0; pl_val = 0;
        tick(); tick();
        chk("R6 por clears, edges ignored", pin_out, 1'b0);
        chk("R6 feedback cleared", fb_out, 1'b0);
        #1 por_n = 1;
        sum_in = 0;
        tick();
    endtask

    task automatic t_capture();
        sum_in = 1; tick();
        chk("R2 capture 1", pin_out, 1'b1);
        sum_in = 0; #1;
        chk("R2 holds between edges", pin_out, 1'b1);
        tick();
        chk("R2 capture 0", pin_out, 1'b0);
    endtask

    task automatic t_preset();
        sum_in = 0; preset = 1; tick();
        chk("R3 preset sets", pin_out, 1'b1);
        preset = 0;
    endtask

    task automatic t_reset_vs_preset();
        areset = 1; #1;
        chk("R1 async clear", pin_out, 1'b0);
        preset = 1; sum_in = 1; tick();
        chk("R4 reset beats preset", pin_out, 1'b0);
        areset = 0; tick();
        chk("R3 preset after reset", pin_out, 1'b1);
        preset = 0; sum_in = 0; tick();
    endtask

    task automatic t_preload();
        preset = 1; sum_in = 1; pl_en = 1; pl_val = 0; tick();
        chk("R5 preload 0 beats preset/sum", pin_out, 1'b0);
        preset = 0; sum_in = 0; pl_val = 1; tick();
        chk("R5 preload 1 beats sum", pin_out, 1'b1);
        areset = 1; tick();
        chk("R1 reset beats preload", pin_out, 1'b0);
        areset = 0; pl_en = 0; tick();
    endtask

    task automatic t_reg_polarity_fb();
        areset = 1; cfg_high = 0; #1;
        chk("R7 cleared active-low drives 1", pin_out, 1'b1);
        chk("R9 fb is true state", fb_out, 1'b0);
        areset = 0; sum_in = 1; tick();
        chk("R7 active-low inverts", pin_out, 1'b0);
        oe_term = 0; pin_in = 0; #1;
        chk("R9 fb ignores pin_in", fb_out, 1'b1);
        chk("R11 oe off", pin_oe, 1'b0);
        oe_term = 1; #1;
        chk("R11 oe on", pin_oe, 1'b1);
    endtask

    task automatic t_comb();
        cfg_comb = 1; cfg_high = 1; sum_in = 0; #1;
        chk("R8 comb follows 0", pin_out, 1'b0);
        sum_in = 1; #1;
        chk("R8 comb follows 1 unclocked", pin_out, 1'b1);
        chk("R10 fb is pin when driven", fb_out, 1'b1);
        cfg_high = 0; #1;
        chk("R8 comb active-low", pin_out, 1'b0);
        chk("R10 fb driven active-low", fb_out, 1'b0);
        oe_term = 0; pin_in = 1; #1;
        chk("R10 fb from pin_in 1", fb_out, 1'b1);
        pin_in = 0; #1;
        chk("R10 fb from pin_in 0", fb_out, 1'b0);
        oe_term = 1;
    endtask

    initial begin
        t_powerup();
        t_capture();
        t_preset();
        t_reset_vs_preset();
        t_preload();
        t_reg_polarity_fb();
        t_comb();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule